// File: doc/BRIEF.md
# CAN Bit-Stream Stuffing and CRC Coder

This block performs the bit-level coding of a CAN-style serial frame for one node. A frame sequencer outside the block presents one unstuffed bit per bit time. It marks each bit with a flag for the stuffing domain (start-of-frame through the last CRC bit), a flag for CRC coverage, and a frame-start flag on the start-of-frame bit. The transmit path turns this into the line bit stream. After five equal line bits inside the domain it inserts a bit of the opposite level. While that extra bit goes out it tells the sequencer to hold the current bit. It also keeps a running 15-bit CRC over the covered bits, which the sequencer then sends as the CRC field.

The receive path takes line bits with the same kind of markings. It drops the inserted bits and passes every other bit on with a valid pulse. A sixth equal level where an inserted bit was due is reported as a stuff error. The receive path runs the same CRC over the frame bits and the received CRC sequence. An intact frame leaves a zero remainder, and any other value is flagged. Bit timing, arbitration and field sequencing belong to the surrounding controller.

Both paths advance only on their bit-enable strobe. Recessive is logic 1 and dominant is logic 0.

Top module: `can_bit_coder`

## Requirements
- R1: After reset, tx_line is 1 (recessive), tx_hold is 0, tx_crc and rx_crc are 0, rx_crc_err is 0, and rx_valid and rx_stuff_err are 0.
- R2: On the transmit side, once five consecutive line bits of equal level have been sent and the fifth carried tx_dom=1, the next line bit is the complement of that level. It appears on tx_line one clock after the tx_bit_en strobe that sends it.
- R3: An inserted stuff bit counts as the first bit of the following run. Four further equal bits after it, all in the domain, cause another insertion.
- R4: tx_hold is 1 exactly during the bit times in which the next tx_bit_en sends a stuff bit. In those bit times the presented bit is not consumed and the CRC does not change. tx_hold is 0 whenever tx_sof is 1.
- R5: No bit is inserted after a line bit sent with tx_dom=0. Only the stuff bit owed by a run that ends on the last in-domain bit is sent before the next out-of-domain bit.
- R6: A strobe with the start-of-frame flag (tx_sof or rx_sof) restarts the run count with that bit as the first bit of the run, and clears the CRC to zero before the bit is included.
- R7: The CRC is 15 bits wide with generator x^15+x^14+x^10+x^8+x^7+x^4+x^3+1 (0x4599) and initial value 0. It is fed most significant bit first, with one update per strobe whose CRC-enable flag is 1, and never for stuff bits. tx_crc equals the remainder of the covered bits multiplied by x^15, divided by the generator.
- R8: The receive side gives one rx_valid pulse, with rx_dout equal to the line bit, one clock after each strobe that carries a bit other than a stuff bit. Stuff bits give no pulse.
- R9: A received bit equal in level to the preceding five in-domain bits gives a one-cycle rx_stuff_err pulse and no rx_valid. Stuff checking is then suspended until the next rx_sof, and later bits pass as data.
- R10: If the frame bits and the received CRC sequence are all fed with rx_crc_en=1, rx_crc ends at 0 for an intact frame. rx_crc_err is 1 whenever rx_crc is nonzero.
- R11: Without a strobe on its bit enable, tx_line keeps its value, and rx_valid and rx_stuff_err stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_bit_en | input | 1 | Transmit bit-time strobe |
| tx_sof | input | 1 | Presented bit is start of frame |
| tx_din | input | 1 | Presented unstuffed bit |
| tx_dom | input | 1 | Presented bit lies in the stuffing domain |
| tx_crc_en | input | 1 | Presented bit is covered by the CRC |
| tx_line | output | 1 | Coded line bit |
| tx_hold | output | 1 | Next strobe sends a stuff bit; keep the presented bit |
| tx_crc | output | 15 | Transmit CRC register |
| rx_bit_en | input | 1 | Receive bit-time strobe |
| rx_sof | input | 1 | Received bit is start of frame |
| rx_line | input | 1 | Received line bit |
| rx_dom | input | 1 | Received bit lies in the stuffing domain |
| rx_crc_en | input | 1 | Received bit feeds the CRC |
| rx_valid | output | 1 | Destuffed bit available |
| rx_dout | output | 1 | Destuffed bit |
| rx_stuff_err | output | 1 | Stuff violation pulse |
| rx_crc | output | 15 | Receive CRC register |
| rx_crc_err | output | 1 | Receive CRC remainder is nonzero |

## Verification
A wrong run count or a wrong remembered level changes tx_line within one bit time. The stream then either gets an extra complement bit or misses one, and every later bit of the frame moves out of position. The same fault in the receiver drops a data bit or lets a stuff bit through, so the rx_valid count for the frame is wrong, or it raises a stuff error on a clean frame. A fault in the CRC register or its feedback stays hidden until the CRC field. It then shows as a wrong tx_crc value or a nonzero receive remainder at the end of that frame. The bench therefore sweeps every 10-bit payload end to end and compares whole frames.

// File: rtl/can_bit_coder_pkg.sv
package can_bit_coder_pkg;

  // Default geometry of the coder
  localparam int unsigned DEF_RUN_LEN = 5;
  localparam int unsigned DEF_CRC_W   = 15;
  localparam logic [DEF_CRC_W-1:0] DEF_CRC_POLY = 15'h4599;

  // How a received line bit is treated
  typedef enum logic [1:0] {
    BK_PASS  = 2'd0,
    BK_STUFF = 2'd1,
    BK_VIOL  = 2'd2
  } bit_kind_e;

endpackage

// File: rtl/coder_run_tracker.sv
module coder_run_tracker #(
  parameter int unsigned RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic restart,
  input  logic bit_lvl,
  input  logic bit_dom,
  output logic at_limit,
  output logic last_lvl
);

  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic             dom_q, dom_d;

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    dom_d = dom_q;
    if (step_en) begin
      lvl_d = bit_lvl;
      dom_d = bit_dom;
      if (restart) begin
        cnt_d = CNT_ONE;
      end else if (bit_dom && (bit_lvl == lvl_q) && (cnt_q != CNT_MAX)) begin
        cnt_d = cnt_q + CNT_ONE;
      end else begin
        cnt_d = CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
      dom_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
      dom_q <= dom_d;
    end
  end

  assign at_limit = dom_q && (cnt_q == CNT_MAX);
  assign last_lvl = lvl_q;

endmodule

// File: rtl/coder_crc_lfsr.sv
module coder_crc_lfsr #(
  parameter int unsigned     W    = 15,
  parameter logic [W-1:0]    POLY = 15'h4599
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         upd,
  input  logic         bit_in,
  output logic [W-1:0] crc
);

  logic [W-1:0] crc_q, crc_d;
  logic [W-1:0] base;
  logic         fb;

  always_comb begin
    base  = clear ? '0 : crc_q;
    fb    = base[W-1] ^ bit_in;
    crc_d = crc_q;
    if (upd) begin
      crc_d = {base[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end else if (clear) begin
      crc_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/coder_tx_stuffer.sv
module coder_tx_stuffer #(
  parameter int unsigned          RUN_LEN  = 5,
  parameter int unsigned          CRC_W    = 15,
  parameter logic [CRC_W-1:0]     CRC_POLY = 15'h4599
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             sof,
  input  logic             din,
  input  logic             dom,
  input  logic             crc_en,
  output logic             line,
  output logic             hold,
  output logic [CRC_W-1:0] crc
);

  logic owe_stuff;
  logic last_lvl;
  logic emit_lvl;
  logic emit_dom;
  logic line_q, line_d;

  // A stuff bit is owed unless a new frame starts
  assign owe_stuff = at_limit_w & ~sof;
  assign hold      = owe_stuff;

  logic at_limit_w;

  always_comb begin
    emit_lvl = owe_stuff ? ~last_lvl : din;
    emit_dom = owe_stuff ? 1'b1      : dom;
    line_d   = line_q;
    if (bit_en) line_d = emit_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b1;
    else        line_q <= line_d;
  end

  assign line = line_q;

  coder_run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (bit_en),
    .restart  (sof),
    .bit_lvl  (emit_lvl),
    .bit_dom  (emit_dom),
    .at_limit (at_limit_w),
    .last_lvl (last_lvl)
  );

  coder_crc_lfsr #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (bit_en & sof),
    .upd    (bit_en & crc_en & ~owe_stuff),
    .bit_in (din),
    .crc    (crc)
  );

endmodule

// File: rtl/coder_rx_destuffer.sv
module coder_rx_destuffer
  import can_bit_coder_pkg::*;
#(
  parameter int unsigned          RUN_LEN  = 5,
  parameter int unsigned          CRC_W    = 15,
  parameter logic [CRC_W-1:0]     CRC_POLY = 15'h4599
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             sof,
  input  logic             line,
  input  logic             dom,
  input  logic             crc_en,
  output logic             valid,
  output logic             dout,
  output logic             stuff_err,
  output logic [CRC_W-1:0] crc
);

  bit_kind_e kind;
  logic      at_limit;
  logic      last_lvl;
  logic      halt_q, halt_d;
  logic      dom_eff;
  logic      valid_q, valid_d;
  logic      dout_q, dout_d;
  logic      err_q, err_d;

  // Classify the current line bit against the run so far
  always_comb begin
    if (sof)                  kind = BK_PASS;
    else if (!at_limit)       kind = BK_PASS;
    else if (line == last_lvl) kind = BK_VIOL;
    else                      kind = BK_STUFF;
  end

  always_comb begin
    dom_eff = sof ? dom : (dom & ~halt_q & (kind != BK_VIOL));
    halt_d  = halt_q;
    valid_d = 1'b0;
    err_d   = 1'b0;
    dout_d  = dout_q;
    if (bit_en) begin
      if (sof)                 halt_d = 1'b0;
      else if (kind == BK_VIOL) halt_d = 1'b1;
      valid_d = (kind == BK_PASS);
      err_d   = (kind == BK_VIOL);
      dout_d  = line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q  <= 1'b0;
      valid_q <= 1'b0;
      dout_q  <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      halt_q  <= halt_d;
      valid_q <= valid_d;
      dout_q  <= dout_d;
      err_q   <= err_d;
    end
  end

  assign valid     = valid_q;
  assign dout      = dout_q;
  assign stuff_err = err_q;

  coder_run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (bit_en),
    .restart  (sof),
    .bit_lvl  (line),
    .bit_dom  (dom_eff),
    .at_limit (at_limit),
    .last_lvl (last_lvl)
  );

  coder_crc_lfsr #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (bit_en & sof),
    .upd    (bit_en & crc_en & (kind == BK_PASS)),
    .bit_in (line),
    .crc    (crc)
  );

endmodule

// File: rtl/can_bit_coder.sv
module can_bit_coder
  import can_bit_coder_pkg::*;
#(
  parameter int unsigned          RUN_LEN  = DEF_RUN_LEN,
  parameter int unsigned          CRC_W    = DEF_CRC_W,
  parameter logic [CRC_W-1:0]     CRC_POLY = DEF_CRC_POLY
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_bit_en,
  input  logic             tx_sof,
  input  logic             tx_din,
  input  logic             tx_dom,
  input  logic             tx_crc_en,
  output logic             tx_line,
  output logic             tx_hold,
  output logic [CRC_W-1:0] tx_crc,
  input  logic             rx_bit_en,
  input  logic             rx_sof,
  input  logic             rx_line,
  input  logic             rx_dom,
  input  logic             rx_crc_en,
  output logic             rx_valid,
  output logic             rx_dout,
  output logic             rx_stuff_err,
  output logic [CRC_W-1:0] rx_crc,
  output logic             rx_crc_err
);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  coder_tx_stuffer #(
    .RUN_LEN(RUN_LEN), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY)
  ) u_tx (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .bit_en (tx_bit_en),
    .sof    (tx_sof),
    .din    (tx_din),
    .dom    (tx_dom),
    .crc_en (tx_crc_en),
    .line   (tx_line),
    .hold   (tx_hold),
    .crc    (tx_crc)
  );

  coder_rx_destuffer #(
    .RUN_LEN(RUN_LEN), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .bit_en    (rx_bit_en),
    .sof       (rx_sof),
    .line      (rx_line),
    .dom       (rx_dom),
    .crc_en    (rx_crc_en),
    .valid     (rx_valid),
    .dout      (rx_dout),
    .stuff_err (rx_stuff_err),
    .crc       (rx_crc)
  );

  assign rx_crc_err = |rx_crc;

endmodule

// File: rtl/can_bit_coder_chk.sv
module can_bit_coder_chk #(
  parameter int unsigned CRC_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_bit_en,
  input logic             tx_sof,
  input logic             tx_din,
  input logic             tx_dom,
  input logic             tx_crc_en,
  input logic             tx_line,
  input logic             tx_hold,
  input logic [CRC_W-1:0] tx_crc,
  input logic             rx_bit_en,
  input logic             rx_sof,
  input logic             rx_line,
  input logic             rx_dom,
  input logic             rx_crc_en,
  input logic             rx_valid,
  input logic             rx_dout,
  input logic             rx_stuff_err,
  input logic [CRC_W-1:0] rx_crc,
  input logic             rx_crc_err
);

  // R4: a held strobe sends the complement of the previous line bit
  p_hold_flips_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_hold && tx_bit_en) |=> (tx_line != $past(tx_line)));

  // R4, R7: stuff bits leave the CRC unchanged
  p_crc_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_hold && tx_bit_en) |=> $stable(tx_crc));

  // R4: no hold while a frame start is presented
  p_hold_sof_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sof |-> !tx_hold);

  // R6: frame start without coverage leaves a cleared CRC
  p_sof_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_bit_en && tx_sof && !tx_crc_en) |=> (tx_crc == '0));

  // R8: a valid bit follows a receive strobe
  p_valid_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rx_bit_en));

  // R9: an error pulse carries no data and lasts one cycle
  p_err_novalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stuff_err |-> !rx_valid);
  p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stuff_err |=> !rx_stuff_err);

  // R10: flag tracks the remainder
  p_crc_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_crc_err == (rx_crc != '0));

  // R11: idle strobes change nothing
  p_tx_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_bit_en |=> $stable(tx_line));
  p_rx_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_bit_en |=> (!rx_valid && !rx_stuff_err));

endmodule

bind can_bit_coder can_bit_coder_chk #(.CRC_W(CRC_W)) u_chk (.*);

// File: tb/tb_can_bit_coder.sv
`timescale 1ns/1ps
module tb_can_bit_coder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_bit_en = 1'b0, tx_sof = 1'b0, tx_din = 1'b1, tx_dom = 1'b0, tx_crc_en = 1'b0;
  logic        tx_line, tx_hold;
  logic [14:0] tx_crc;
  logic        rx_bit_en = 1'b0, rx_sof = 1'b0, rx_line = 1'b1, rx_dom = 1'b0, rx_crc_en = 1'b0;
  logic        rx_valid, rx_dout, rx_stuff_err, rx_crc_err;
  logic [14:0] rx_crc;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  can_bit_coder dut (.*);

  // frame description: bit, domain, crc coverage, frame start
  logic fb [0:63];
  logic fd [0:63];
  logic fc [0:63];
  logic fs [0:63];
  int   nf;
  // expected line
  logic lb [0:127];
  logic ld [0:127];
  logic lc [0:127];
  logic ls [0:127];
  logic lf [0:127];
  int   nl;
  // observed
  logic got [0:127];
  logic hs  [0:127];
  int   ntx;
  logic rxo [0:127];
  int   nr;
  int   nerr;

  task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic push(input logic b, input logic d, input logic c, input logic s);
    fb[nf] = b; fd[nf] = d; fc[nf] = c; fs[nf] = s; nf++;
  endtask

  // Remainder of covered bits times x^15 by long division (generator 0xC599 incl. x^15)
  task automatic calc_crc(output logic [14:0] r);
    logic msg [0:63];
    int   nm = 0;
    logic [15:0] acc = '0;
    for (int i = 0; i < nf; i++) begin
      if (fs[i]) nm = 0;
      if (fc[i]) begin msg[nm] = fb[i]; nm++; end
    end
    for (int i = 0; i < nm + 15; i++) begin
      acc = {acc[14:0], (i < nm) ? msg[i] : 1'b0};
      if (acc[15]) acc = acc ^ 16'hC599;
    end
    r = acc[14:0];
  endtask

  task automatic build_frame(input logic [9:0] d, input logic [14:0] crc_flip, output logic [14:0] c);
    nf = 0;
    push(1'b0, 1'b1, 1'b1, 1'b1);
    for (int i = 9; i >= 0; i--) push(d[i], 1'b1, 1'b1, 1'b0);
    calc_crc(c);
    for (int i = 14; i >= 0; i--) push(c[i] ^ crc_flip[i], 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) push(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  // Expected line stream from the stuffing rules
  task automatic make_line();
    int   run = 0;
    logic last = 1'b1;
    logic pdom = 1'b0;
    nl = 0;
    for (int i = 0; i < nf; i++) begin
      if (!fs[i] && pdom && run == 5) begin
        lb[nl] = ~last; ld[nl] = 1'b1; lc[nl] = 1'b0; ls[nl] = 1'b1; lf[nl] = 1'b0; nl++;
        last = ~last; run = 1;
      end
      lb[nl] = fb[i]; ld[nl] = fd[i]; lc[nl] = fd[i]; ls[nl] = 1'b0; lf[nl] = fs[i]; nl++;
      if (fs[i]) run = 1;
      else if (fd[i] && fb[i] == last) run++;
      else run = 1;
      last = fb[i];
      pdom = fd[i];
    end
  endtask

  task automatic run_tx();
    int idx = 0;
    int k = 0;
    while (idx < nf && k < 120) begin
      @(negedge clk);
      if (k > 0) got[k-1] = tx_line;
      tx_bit_en = 1'b1; tx_sof = fs[idx]; tx_din = fb[idx]; tx_dom = fd[idx]; tx_crc_en = fc[idx];
      #1;
      hs[k] = tx_hold;
      if (!tx_hold) idx++;
      k++;
    end
    @(negedge clk);
    got[k-1] = tx_line;
    tx_bit_en = 1'b0; tx_sof = 1'b0; tx_din = 1'b1; tx_dom = 1'b0; tx_crc_en = 1'b0;
    ntx = k;
  endtask

  task automatic rx_capture();
    if (rx_valid) begin rxo[nr] = rx_dout; nr++; end
    if (rx_stuff_err) nerr++;
  endtask

  task automatic run_rx();
    nr = 0; nerr = 0;
    for (int j = 0; j < nl; j++) begin
      @(negedge clk);
      rx_capture();
      rx_bit_en = 1'b1; rx_sof = lf[j]; rx_line = lb[j]; rx_dom = ld[j]; rx_crc_en = lc[j];
    end
    @(negedge clk);
    rx_capture();
    rx_bit_en = 1'b0; rx_sof = 1'b0; rx_line = 1'b1; rx_dom = 1'b0; rx_crc_en = 1'b0;
    @(negedge clk);
    rx_capture();
  endtask

  task automatic check_tx_line(input string tag);
    logic [127:0] gv = '0, ev = '0, hv = '0, sv = '0;
    for (int i = 0; i < ntx; i++) begin gv[i] = got[i]; hv[i] = hs[i]; end
    for (int i = 0; i < nl; i++)  begin ev[i] = lb[i]; sv[i] = ls[i]; end
    chk(ntx == nl, {tag, " line length R2"}, 128'(ntx), 128'(nl));
    chk(gv == ev, {tag, " stuffed line R2 R3 R5"}, gv, ev);
    chk(hv == sv, {tag, " hold positions R4"}, hv, sv);
  endtask

  task automatic check_rx_bits();
    logic [127:0] gv = '0, ev = '0;
    for (int i = 0; i < nr; i++) gv[i] = rxo[i];
    for (int i = 0; i < nf; i++) ev[i] = fb[i];
    chk((nr == nf) && (gv == ev), "destuffed bits R8", gv, ev);
    chk(nerr == 0, "no stuff error on clean frame R9", 128'(nerr), 128'(0));
  endtask

  initial begin
    logic [14:0] c;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(tx_line == 1'b1 && tx_hold == 1'b0, "reset tx outputs R1", {tx_line, tx_hold}, 2'b10);
    chk(tx_crc == 0 && rx_crc == 0 && !rx_crc_err, "reset crc R1", {tx_crc, rx_crc}, 0);
    chk(!rx_valid && !rx_stuff_err, "reset rx flags R1", {rx_valid, rx_stuff_err}, 0);

    // Sweep every 10-bit payload through both paths
    for (int d = 0; d < 1024; d++) begin
      build_frame(10'(d), 15'd0, c);
      make_line();
      run_tx();
      check_tx_line("sweep");
      chk(tx_crc == c, "tx crc value R7", 128'(tx_crc), 128'(c));
      run_rx();
      check_rx_bits();
      chk(rx_crc == 0 && !rx_crc_err, "rx remainder zero R10", {rx_crc, rx_crc_err}, 0);
    end

    // R10: corrupted CRC field gives a nonzero remainder
    for (int d = 0; d < 16; d++) begin
      build_frame(10'(d * 61), 15'(1 << (d % 15)), c);
      make_line();
      run_rx();
      chk(rx_crc_err == 1'b1, "corrupt crc flagged R10", 128'(rx_crc_err), 128'(1));
    end

    // R6: a second frame start in mid-run restarts the count and the CRC
    nf = 0;
    push(1'b0, 1'b1, 1'b1, 1'b1);
    push(1'b0, 1'b1, 1'b1, 1'b0);
    push(1'b0, 1'b1, 1'b1, 1'b0);
    push(1'b0, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) push(1'b0, 1'b1, 1'b1, 1'b0);
    push(1'b1, 1'b1, 1'b1, 1'b0);
    push(1'b1, 1'b0, 1'b0, 1'b0);
    make_line();
    calc_crc(c);
    run_tx();
    check_tx_line("restart R6");
    chk(tx_crc == c, "crc restarted at frame start R6", 128'(tx_crc), 128'(c));
    chk(ls[8] == 1'b1 && nl == 11, "bench model stuff after restart R6", 128'(nl), 128'(11));

    // R9: six equal bits raise one error, then checking is suspended
    nl = 0;
    for (int i = 0; i < 7; i++) begin
      lb[i] = 1'b0; ld[i] = 1'b1; lc[i] = 1'b0; ls[i] = 1'b0; lf[i] = (i == 0); nl++;
    end
    run_rx();
    chk(nerr == 1, "single stuff error R9", 128'(nerr), 128'(1));
    chk(nr == 6, "bits passed around error R9", 128'(nr), 128'(6));

    // R11: no strobe, no change
    @(negedge clk);
    tx_din = 1'b0; tx_dom = 1'b1; rx_line = 1'b0;
    repeat (5) @(negedge clk);
    chk(tx_line == 1'b1, "tx line idle R11", 128'(tx_line), 128'(1));
    chk(!rx_valid && !rx_stuff_err, "rx idle R11", {rx_valid, rx_stuff_err}, 0);
    tx_din = 1'b1; tx_dom = 1'b0; rx_line = 1'b1;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule